// File: doc/BRIEF.md
# Pin I/O Controller with Edge Interrupts

This block drives and samples a bank of general-purpose pins on behalf of a processor. Software programs it through a 32-bit memory-mapped slave port with a cycle/strobe handshake. The port offers eight word registers: sampled inputs, output value, output enable, interrupt enable, edge polarity, alternate-source select, control and pending status. On the pin side the block takes an input bus, a sampling clock coming from a pin, and an alternate input bus. It returns an output bus and an active-low enable bus.

The input register can follow the pins on every bus clock. It can also latch them only on a chosen edge of the pin clock, which the block treats as an ordinary sampled signal. Each output pin is driven either by the output register or by the matching alternate input. Interrupts are captured per pin on a selectable edge, held until software clears them, and gated onto a single request line by a global enable.

Top module: `gpio_ctrl`

## Requirements
- R1: After reset every register reads 0, the output bus is 0, the active-low enable bus is all ones and the request line is low.
- R2: A bus access is acknowledged in the cycle after cyc and stb are both high. A byte address above 0x1C returns err instead of ack, and a write to such an address changes no register.
- R3: Register byte offsets are 0x00 input, 0x04 output, 0x08 enable, 0x0C interrupt enable, 0x10 polarity, 0x14 alternate select, 0x18 control and 0x1C status. Writes update only the bytes whose sel bit is set, and registers read back what was written.
- R4: With control bit 0 clear, the input register follows the pins one bus clock later. The input register is read-only, so a write to it is ignored.
- R5: With control bit 0 set and control bit 1 clear, the input register loads the pins only on a rising edge of the pin clock. Between edges it holds its value.
- R6: With control bits 0 and 1 both set, the input register loads the pins only on a falling edge of the pin clock.
- R7: Each bit of the active-low enable bus is the inverse of the corresponding enable register bit.
- R8: Each output pin carries the alternate input bit when its select bit is 1, and the output register bit otherwise.
- R9: With a pin's polarity bit at 0 and its interrupt-enable bit at 1, a 1-to-0 change of the sampled input sets that pin's status bit. The bit stays set until software writes to the status register.
- R10: With the polarity bit at 1, a 0-to-1 change sets the status bit instead. Constant inputs, or changes on pins whose interrupt enable is 0, set nothing.
- R11: The request line equals control bit 2 ANDed with the OR of all status bits. Writing 0 to the control register drops the request line, and the status bits stay readable.
- R12: Writing 0 to the status register clears every pending bit.
- R13: Control bit 3 reads as the current state of the request line, and writes to it are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Active-high asynchronous reset |
| bus_cyc | input | 1 | Bus cycle valid |
| bus_stb | input | 1 | Bus strobe |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_sel | input | 4 | Byte lane selects for writes |
| bus_adr | input | AW (8) | Byte address |
| bus_wdat | input | 32 | Write data |
| bus_rdat | output | 32 | Read data, valid with ack |
| bus_ack | output | 1 | Access completed |
| bus_err | output | 1 | Access to an unmapped address |
| irq | output | 1 | Interrupt request |
| pin_in | input | NPIN (32) | Pin input values |
| pin_sclk | input | 1 | Sampling clock taken from a pin |
| alt_in | input | NPIN (32) | Alternate output sources |
| pin_out | output | NPIN (32) | Pin output values |
| pin_oe_n | output | NPIN (32) | Active-low pin output enables |

## Verification
The output path is tried with a walking one and a walking zero across all pins, and with arithmetic mixes of select, alternate and register values. Together these show whether each pin uses its own select bit and whether the mux sources are swapped. The interrupt path is swept pin by pin in both polarities, with a second, disabled pin toggled alongside. This separates edge direction, per-pin enable and the sticky status from one another. For input sampling, pin values change between pin-clock edges, and the register must show either the edge-time value or the bus-clock-time value, which tells the three modes apart.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int BUS_W = 32;
  localparam int SEL_W = BUS_W / 8;

  typedef enum logic [2:0] {
    RG_IN  = 3'd0,
    RG_OUT = 3'd1,
    RG_OE  = 3'd2,
    RG_IE  = 3'd3,
    RG_POL = 3'd4,
    RG_ALT = 3'd5,
    RG_CTL = 3'd6,
    RG_STS = 3'd7
  } reg_sel_e;

  // control register bit positions
  localparam int CTL_EXT  = 0;
  localparam int CTL_NEG  = 1;
  localparam int CTL_IE   = 2;
  localparam int CTL_PEND = 3;
  localparam int CTL_W    = 3;

  // expand byte selects into a bit mask
  function automatic logic [BUS_W-1:0] lane_mask(input logic [SEL_W-1:0] sel);
    logic [BUS_W-1:0] m;
    for (int b = 0; b < SEL_W; b++) m[b*8 +: 8] = {8{sel[b]}};
    return m;
  endfunction

  // replace masked bits of old value with new value
  function automatic logic [BUS_W-1:0] merge(input logic [BUS_W-1:0] old_v,
                                             input logic [BUS_W-1:0] new_v,
                                             input logic [BUS_W-1:0] m);
    return (old_v & ~m) | (new_v & m);
  endfunction

  // per-bit edge detect: pol=1 rising, pol=0 falling
  function automatic logic [BUS_W-1:0] edge_hit(input logic [BUS_W-1:0] cur,
                                                input logic [BUS_W-1:0] prv,
                                                input logic [BUS_W-1:0] pol);
    return (pol & cur & ~prv) | (~pol & ~cur & prv);
  endfunction
endpackage

// File: rtl/gpio_bus_port.sv
module gpio_bus_port
  import gpio_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cyc,
  input  logic          stb,
  input  logic          we,
  input  logic [AW-1:0] adr,
  output logic          ack,
  output logic          err,
  output logic          acc_go,
  output logic          wr_go,
  output reg_sel_e      idx
);
  localparam int IDX_LO = 2;
  localparam int IDX_HI = 4;

  logic req;
  logic in_range;

  assign req      = cyc & stb & ~ack & ~err;
  assign in_range = (adr[AW-1:IDX_HI+1] == '0);
  assign acc_go   = req & in_range;
  assign wr_go    = acc_go & we;
  assign idx      = reg_sel_e'(adr[IDX_HI:IDX_LO]);

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      ack <= 1'b0;
      err <= 1'b0;
    end else begin
      ack <= req & in_range;
      err <= req & ~in_range;
    end
  end

  AST_ACK_ERR_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(ack && err)); // R2
  AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (rst)
    ack |=> !ack); // R2
  AST_ACK_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (rst)
    (cyc && stb && !ack && !err) |=> (ack || err)); // R2
endmodule

// File: rtl/gpio_in_sample.sv
module gpio_in_sample #(
  parameter int NPIN = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NPIN-1:0] pins,
  input  logic            sclk,
  input  logic            ext_en,
  input  logic            neg_sel,
  output logic [NPIN-1:0] smp
);
  logic sclk_q;
  logic sclk_rise;
  logic sclk_fall;
  logic load;

  assign sclk_rise = sclk & ~sclk_q;
  assign sclk_fall = ~sclk & sclk_q;
  assign load      = ~ext_en | (neg_sel ? sclk_fall : sclk_rise);

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      sclk_q <= 1'b0;
      smp    <= '0;
    end else begin
      sclk_q <= sclk;
      if (load) smp <= pins;
    end
  end

  AST_IN_HOLD: assert property (@(posedge clk) disable iff (rst)
    (ext_en && !(neg_sel ? (!sclk && sclk_q) : (sclk && !sclk_q))) |=> $stable(smp)); // R5
  AST_IN_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    !ext_en |=> (smp == $past(pins))); // R4
endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit
  import gpio_pkg::*;
#(
  parameter int NPIN = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NPIN-1:0] smp,
  input  logic [NPIN-1:0] ie_mask,
  input  logic [NPIN-1:0] pol,
  input  logic            sts_wr,
  input  logic [NPIN-1:0] sts_wdat,
  input  logic [NPIN-1:0] sts_wmask,
  output logic [NPIN-1:0] sts,
  output logic [NPIN-1:0] hit
);
  logic [NPIN-1:0] prv;
  logic [NPIN-1:0] sts_base;

  assign hit = ie_mask & NPIN'(edge_hit(BUS_W'(smp), BUS_W'(prv), BUS_W'(pol)));

  always_comb begin
    sts_base = sts;
    if (sts_wr) sts_base = (sts & ~sts_wmask) | (sts_wdat & sts_wmask);
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      prv <= '0;
      sts <= '0;
    end else begin
      prv <= smp;
      sts <= sts_base | hit;
    end
  end

  AST_STS_STICKY: assert property (@(posedge clk) disable iff (rst)
    !sts_wr |=> ((sts & $past(sts)) == $past(sts))); // R9
  AST_NO_EDGE_NO_SET: assert property (@(posedge clk) disable iff (rst)
    (!sts_wr && hit == '0) |=> $stable(sts)); // R10
  AST_CLEAR_ALL: assert property (@(posedge clk) disable iff (rst)
    (sts_wr && sts_wdat == '0 && sts_wmask == '1 && hit == '0) |=> (sts == '0)); // R12
endmodule

// File: rtl/gpio_ctrl.sv
module gpio_ctrl
  import gpio_pkg::*;
#(
  parameter int NPIN = 32,
  parameter int AW   = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_cyc,
  input  logic             bus_stb,
  input  logic             bus_we,
  input  logic [SEL_W-1:0] bus_sel,
  input  logic [AW-1:0]    bus_adr,
  input  logic [BUS_W-1:0] bus_wdat,
  output logic [BUS_W-1:0] bus_rdat,
  output logic             bus_ack,
  output logic             bus_err,
  output logic             irq,
  input  logic [NPIN-1:0]  pin_in,
  input  logic             pin_sclk,
  input  logic [NPIN-1:0]  alt_in,
  output logic [NPIN-1:0]  pin_out,
  output logic [NPIN-1:0]  pin_oe_n
);
  logic             acc_go;
  logic             wr_go;
  reg_sel_e         idx;
  logic [BUS_W-1:0] wm;

  logic [NPIN-1:0]  out_q, oe_q, ie_q, pol_q, alt_q;
  logic [CTL_W-1:0] ctl_q;
  logic [NPIN-1:0]  smp;
  logic [NPIN-1:0]  sts;
  logic [NPIN-1:0]  hit;
  logic             sts_wr;
  logic [BUS_W-1:0] ctl_view;
  logic [BUS_W-1:0] rd_mux;

  assign wm = lane_mask(bus_sel);

  gpio_bus_port #(.AW(AW)) u_bus (
    .clk    (clk),
    .rst    (rst),
    .cyc    (bus_cyc),
    .stb    (bus_stb),
    .we     (bus_we),
    .adr    (bus_adr),
    .ack    (bus_ack),
    .err    (bus_err),
    .acc_go (acc_go),
    .wr_go  (wr_go),
    .idx    (idx)
  );

  gpio_in_sample #(.NPIN(NPIN)) u_smp (
    .clk     (clk),
    .rst     (rst),
    .pins    (pin_in),
    .sclk    (pin_sclk),
    .ext_en  (ctl_q[CTL_EXT]),
    .neg_sel (ctl_q[CTL_NEG]),
    .smp     (smp)
  );

  assign sts_wr = wr_go && (idx == RG_STS);

  gpio_irq_unit #(.NPIN(NPIN)) u_irq (
    .clk       (clk),
    .rst       (rst),
    .smp       (smp),
    .ie_mask   (ie_q),
    .pol       (pol_q),
    .sts_wr    (sts_wr),
    .sts_wdat  (bus_wdat[NPIN-1:0]),
    .sts_wmask (wm[NPIN-1:0]),
    .sts       (sts),
    .hit       (hit)
  );

  // register writes; the input register has no write path
  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      out_q <= '0;
      oe_q  <= '0;
      ie_q  <= '0;
      pol_q <= '0;
      alt_q <= '0;
      ctl_q <= '0;
    end else if (wr_go) begin
      case (idx)
        RG_OUT: out_q <= NPIN'(merge(BUS_W'(out_q), bus_wdat, wm));
        RG_OE:  oe_q  <= NPIN'(merge(BUS_W'(oe_q),  bus_wdat, wm));
        RG_IE:  ie_q  <= NPIN'(merge(BUS_W'(ie_q),  bus_wdat, wm));
        RG_POL: pol_q <= NPIN'(merge(BUS_W'(pol_q), bus_wdat, wm));
        RG_ALT: alt_q <= NPIN'(merge(BUS_W'(alt_q), bus_wdat, wm));
        RG_CTL: ctl_q <= CTL_W'(merge(BUS_W'(ctl_q), bus_wdat, wm));
        default: ;
      endcase
    end
  end

  assign irq = ctl_q[CTL_IE] & (|sts);

  always_comb begin
    ctl_view           = BUS_W'(ctl_q);
    ctl_view[CTL_PEND] = irq;
  end

  always_comb begin
    case (idx)
      RG_IN:   rd_mux = BUS_W'(smp);
      RG_OUT:  rd_mux = BUS_W'(out_q);
      RG_OE:   rd_mux = BUS_W'(oe_q);
      RG_IE:   rd_mux = BUS_W'(ie_q);
      RG_POL:  rd_mux = BUS_W'(pol_q);
      RG_ALT:  rd_mux = BUS_W'(alt_q);
      RG_CTL:  rd_mux = ctl_view;
      default: rd_mux = BUS_W'(sts);
    endcase
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst)         bus_rdat <= '0;
    else if (acc_go) bus_rdat <= rd_mux;
  end

  // pin side: per-pin source mux and inverted enables
  for (genvar g = 0; g < NPIN; g++) begin : g_pin
    assign pin_out[g]  = alt_q[g] ? alt_in[g] : out_q[g];
    assign pin_oe_n[g] = ~oe_q[g];
  end

  AST_OEN_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(wr_go && idx == RG_OE) |=> $stable(pin_oe_n)); // R7
  AST_CTL_ZERO_DROPS_IRQ: assert property (@(posedge clk) disable iff (rst)
    (wr_go && idx == RG_CTL && bus_sel[0] && !bus_wdat[CTL_IE]) |=> !irq); // R11
  AST_ERR_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (bus_cyc && bus_stb && bus_we && !bus_ack && !bus_err && bus_adr[AW-1:5] != '0)
      |=> ($stable(out_q) && $stable(ctl_q))); // R2
endmodule

// File: tb/sim_gpio_ctrl.sv
module sim_gpio_ctrl;
  localparam int NPIN = 32;
  localparam int AW   = 8;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              bus_cyc = 1'b0, bus_stb = 1'b0, bus_we = 1'b0;
  logic [3:0]        bus_sel = 4'h0;
  logic [AW-1:0]     bus_adr = '0;
  logic [31:0]       bus_wdat = '0;
  logic [31:0]       bus_rdat;
  logic              bus_ack, bus_err, irq;
  logic [NPIN-1:0]   pin_in = '0;
  logic              pin_sclk = 1'b0;
  logic [NPIN-1:0]   alt_in = '0;
  logic [NPIN-1:0]   pin_out, pin_oe_n;

  int total = 0;
  int bad   = 0;

  always #5 clk = ~clk;

  gpio_ctrl #(.NPIN(NPIN), .AW(AW)) u0 (
    .clk(clk), .rst(rst), .bus_cyc(bus_cyc), .bus_stb(bus_stb), .bus_we(bus_we),
    .bus_sel(bus_sel), .bus_adr(bus_adr), .bus_wdat(bus_wdat), .bus_rdat(bus_rdat),
    .bus_ack(bus_ack), .bus_err(bus_err), .irq(irq), .pin_in(pin_in),
    .pin_sclk(pin_sclk), .alt_in(alt_in), .pin_out(pin_out), .pin_oe_n(pin_oe_n)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one bus access; returns data, ack, err sampled after the acking edge
  task automatic bus_op(input logic we, input logic [AW-1:0] a, input logic [31:0] d,
                        input logic [3:0] s, output logic [31:0] q,
                        output logic ak, output logic er);
    @(negedge clk);
    bus_cyc = 1'b1; bus_stb = 1'b1; bus_we = we; bus_adr = a; bus_wdat = d; bus_sel = s;
    @(posedge clk); #1;
    q = bus_rdat; ak = bus_ack; er = bus_err;
    @(negedge clk);
    bus_cyc = 1'b0; bus_stb = 1'b0; bus_we = 1'b0;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    logic [31:0] q; logic ak, er;
    bus_op(1'b1, a, d, 4'hF, q, ak, er);
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] q);
    logic ak, er;
    bus_op(1'b0, a, 32'h0, 4'hF, q, ak, er);
  endtask

  task automatic cyc_wait(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] q, e;
    logic ak, er;

    cyc_wait(3);
    rst = 1'b0;
    cyc_wait(1);

    // R1 reset state
    chk("R1 pin_out", pin_out, 32'h0);
    chk("R1 pin_oe_n", pin_oe_n, 32'hFFFF_FFFF);
    chk("R1 irq", 32'(irq), 32'h0);
    for (int r = 0; r < 8; r++) begin
      rd(AW'(r * 4), q);
      chk("R1 register reset", q, 32'h0);
    end

    // R2 ack timing and err on unmapped address
    bus_op(1'b0, 8'h04, 32'h0, 4'hF, q, ak, er);
    chk("R2 ack", {30'h0, ak, er}, 32'h2);
    bus_op(1'b1, 8'h24, 32'hDEAD_BEEF, 4'hF, q, ak, er);
    chk("R2 err write", {30'h0, ak, er}, 32'h1);
    bus_op(1'b0, 8'h80, 32'h0, 4'hF, q, ak, er);
    chk("R2 err read", {30'h0, ak, er}, 32'h1);
    rd(8'h04, q);
    chk("R2 unmapped write ignored", q, 32'h0);

    // R3 byte lanes and readback
    bus_op(1'b1, 8'h04, 32'hFFFF_FFFF, 4'b0101, q, ak, er);
    rd(8'h04, q);
    chk("R3 byte sel", q, 32'h00FF_00FF);
    for (int r = 1; r < 6; r++) begin
      e = 32'h1357_9BDF * (r + 3);
      wr(AW'(r * 4), e);
      rd(AW'(r * 4), q);
      chk("R3 readback", q, e);
    end
    wr(8'h18, 32'hFFFF_FFFF);
    rd(8'h18, q);
    chk("R13 ctl pend read-only", q, 32'h7);
    for (int r = 1; r < 7; r++) wr(AW'(r * 4), 32'h0);

    // R4 bus-clock sampling
    for (int k = 0; k < 8; k++) begin
      @(negedge clk); pin_in = 32'hA5C3_0F01 * (k + 1);
      cyc_wait(2);
      rd(8'h00, q);
      chk("R4 follow", q, 32'hA5C3_0F01 * (k + 1));
    end

    // R5 rising pin-clock capture
    @(negedge clk); pin_in = 32'h0; pin_sclk = 1'b0;
    cyc_wait(2);
    wr(8'h18, 32'h1);
    @(negedge clk); pin_in = 32'h1111_2222;
    cyc_wait(3);
    rd(8'h00, q);
    chk("R5 hold before edge", q, 32'h0);
    wr(8'h00, 32'hFFFF_FFFF);
    rd(8'h00, q);
    chk("R4 input write ignored", q, 32'h0);
    @(negedge clk); pin_sclk = 1'b1;
    cyc_wait(2);
    @(negedge clk); pin_in = 32'h3333_4444;
    cyc_wait(2);
    rd(8'h00, q);
    chk("R5 rise capture", q, 32'h1111_2222);
    @(negedge clk); pin_sclk = 1'b0;
    cyc_wait(2);
    rd(8'h00, q);
    chk("R5 fall ignored", q, 32'h1111_2222);
    @(negedge clk); pin_sclk = 1'b1;
    cyc_wait(2);
    rd(8'h00, q);
    chk("R5 second rise", q, 32'h3333_4444);

    // R6 falling pin-clock capture
    wr(8'h18, 32'h3);
    @(negedge clk); pin_in = 32'h5555_6666;
    cyc_wait(2);
    @(negedge clk); pin_sclk = 1'b0;
    cyc_wait(2);
    @(negedge clk); pin_in = 32'h7777_8888;
    @(negedge clk); pin_sclk = 1'b1;
    cyc_wait(2);
    rd(8'h00, q);
    chk("R6 fall capture, rise ignored", q, 32'h5555_6666);
    @(negedge clk); pin_sclk = 1'b0;
    cyc_wait(2);
    rd(8'h00, q);
    chk("R6 second fall", q, 32'h7777_8888);
    wr(8'h18, 32'h0);

    // R7 inverted enables: walking one and walking zero
    for (int p = 0; p < NPIN; p++) begin
      wr(8'h08, 32'h1 << p);
      chk("R7 walk one", pin_oe_n, ~(32'h1 << p));
      wr(8'h08, ~(32'h1 << p));
      chk("R7 walk zero", pin_oe_n, 32'h1 << p);
    end

    // R8 output source mux
    for (int k = 0; k < 16; k++) begin
      logic [31:0] s, a, o;
      s = 32'h9E37_79B1 * (k + 1);
      a = 32'h7F4A_7C15 * (k + 2);
      o = 32'hC2B2_AE35 * (k + 3);
      @(negedge clk); alt_in = a;
      wr(8'h14, s);
      wr(8'h04, o);
      chk("R8 mux", pin_out, (s & a) | (~s & o));
    end
    wr(8'h14, 32'h0);

    // R10 constant inputs raise nothing
    @(negedge clk); pin_in = 32'hFFFF_FFFF;
    cyc_wait(2);
    wr(8'h1C, 32'h0);
    wr(8'h0C, 32'hFFFF_FFFF);
    wr(8'h18, 32'h4);
    cyc_wait(10);
    rd(8'h1C, q);
    chk("R10 constant status", q, 32'h0);
    chk("R10 constant irq", 32'(irq), 32'h0);

    // R9 / R10 per-pin sweep in both polarities
    for (int pl = 0; pl < 2; pl++) begin
      for (int p = 0; p < NPIN; p++) begin
        int o2;
        o2 = (p + 7) % NPIN;
        @(negedge clk); pin_in = pl ? 32'h0 : 32'hFFFF_FFFF;
        wr(8'h10, pl ? 32'hFFFF_FFFF : 32'h0);
        wr(8'h0C, 32'h1 << p);
        cyc_wait(3);
        wr(8'h1C, 32'h0);
        @(negedge clk); pin_in = (pl ? 32'h0 : 32'hFFFF_FFFF) ^ (32'h1 << p) ^ (32'h1 << o2);
        cyc_wait(3);
        rd(8'h1C, q);
        chk(pl ? "R10 rise sets own bit" : "R9 fall sets own bit", q, 32'h1 << p);
        chk(pl ? "R10 irq" : "R9 irq", 32'(irq), 32'h1);
        // reverse edge must not add anything; bit stays sticky
        @(negedge clk); pin_in = pl ? 32'h0 : 32'hFFFF_FFFF;
        cyc_wait(3);
        rd(8'h1C, q);
        chk("R9 sticky, wrong edge ignored", q, 32'h1 << p);
      end
    end

    // R13 pending flag, R11 gate, R12 clear
    rd(8'h18, q);
    chk("R13 ctl pend", q, 32'hC);
    wr(8'h18, 32'h0);
    chk("R11 irq dropped", 32'(irq), 32'h0);
    rd(8'h1C, q);
    chk("R11 status kept", q, 32'h8000_0000);
    rd(8'h18, q);
    chk("R13 ctl no pend", q, 32'h0);
    wr(8'h1C, 32'h0);
    rd(8'h1C, q);
    chk("R12 status cleared", q, 32'h0);
    wr(8'h18, 32'h4);
    chk("R11 irq low after clear", 32'(irq), 32'h0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule